// File: doc/BRIEF.md
# Relative Branch Resolution Unit

This block works out where a small 8-bit CPU goes next after an instruction from its branch group. The decoder gives it a branch class, an operand kind, and a bit index for bit tests. The CPU supplies the current 16-bit program counter, an absolute 16-bit target, a signed 8-bit displacement, the A and X registers, the carry and zero flags, and the value of the bit being tested. It also supplies the read and write wait-state counts for memory-indirect operands. The block returns the next program counter, whether the branch was taken, the instruction's clock count, and, for a taken test-and-clear branch, a one-hot request to clear the tested bit.

A resolution starts with a one-cycle `start` pulse while the block is idle. A three-state sequencer steps IDLE → EVAL → RESULT → IDLE:

- **IDLE → EVAL (accept):** the operands are captured.
- **EVAL → RESULT (resolve):** every result is registered.
- **RESULT → IDLE (retire):** `done_o` is high for the one cycle spent in RESULT.

The bit-clear request is valid in that same RESULT cycle. A flag register can therefore drop a cleared status bit in the cycle the branch resolves. Relative targets are the address of the following instruction plus the sign-extended displacement, modulo 2^16. The length of the instruction depends on the branch class and the operand kind.

Top module: `brr_unit`

## Requirements
- R1: While reset is held and after it is released, done_o, taken_o, clr_we_o, clr_mask_o, next_pc_o and cycles_o are all zero until the first result.
- R2: A start pulse in IDLE samples all inputs at that clock edge. done_o is then high for exactly one cycle, starting two clock edges later. A start that arrives while a resolution is in flight is ignored.
- R3: op_i=0 (absolute jump) gives next_pc_o=addr_i. op_i=2 (register jump) gives next_pc_o={acc_i,x_i}. Both always report taken_o=1.
- R4: op_i=1 (relative jump) always gives next_pc_o = pc_i + 2 + sign-extended disp_i, wrapping modulo 2^16, with taken_o=1.
- R5: The flag branches branch to pc_i + 2 + displacement under these conditions:
  - op_i=3 when cy_i=1
  - op_i=4 when cy_i=0
  - op_i=5 when z_i=1
  - op_i=6 when z_i=0
- R6: The bit branches are op_i=7 (branch if set), op_i=8 (branch if clear) and op_i=9 (test-and-clear).
  - Operand kinds (kind_i): 0 direct page, 1 special register, 2 accumulator, 3 status word, 4 HL-indirect.
  - Instruction length for op 7: 4 for kind 1, otherwise 3.
  - Instruction length for ops 8 and 9: 4 for kinds 0, 1 and 3, otherwise 3.
  - For kind 2 the tested bit is acc_i[bit_idx_i] and bit_val_i is ignored. For all other kinds it is bit_val_i.
- R7: A conditional branch that is not taken gives next_pc_o = pc_i + instruction length, with taken_o=0.
- R8: op_i=9 is taken only when the tested bit is 1. In that case clr_we_o=1 in the done cycle, clr_mask_o has only bit bit_idx_i set, and clr_space_o=kind_i. When it is not taken, clr_we_o=0 and clr_mask_o=0.
- R9: cycles_o gives the clock count for each class:
  - 12 for ops 0, 1 and 3–6; 16 for op 2.
  - op 7: kinds 0/1/2/3 give 16/22/16/16.
  - op 8: kinds 0/1/2/3 give 20/22/16/22.
  - op 9: kinds 0/1/2/3 give 20/24/16/24.
- R10: For the HL-indirect kind, op 7 and op 8 take 20 + 2×rd_wait_i clocks, and op 9 takes 24 + 2×rd_wait_i + 2×wr_wait_i clocks.
- R11: op_i values 10–15 give next_pc_o=pc_i, taken_o=0, cycles_o=0 and no clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a resolution (honoured in IDLE only) |
| op_i | input | 4 | Branch class code |
| kind_i | input | 3 | Bit-operand kind code |
| bit_idx_i | input | 3 | Index of the tested bit |
| pc_i | input | 16 | Address of the branch instruction |
| addr_i | input | 16 | Absolute target operand |
| disp_i | input | 8 | Signed displacement |
| acc_i | input | 8 | A register |
| x_i | input | 8 | X register |
| cy_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| bit_val_i | input | 1 | Fetched value of the tested bit (non-accumulator kinds) |
| rd_wait_i | input | 2 | Read wait states of the indirect operand |
| wr_wait_i | input | 2 | Write wait states of the indirect operand |
| done_o | output | 1 | Results valid, one cycle |
| next_pc_o | output | 16 | Resolved program counter |
| taken_o | output | 1 | Branch was taken |
| clr_we_o | output | 1 | Clear the tested bit now |
| clr_space_o | output | 3 | Operand kind of the bit to clear |
| clr_mask_o | output | 8 | One-hot mask of the bit to clear |
| cycles_o | output | 8 | Instruction clock count |

## Verification
The bench targets the mixed instruction lengths. Swapping the 3 and 4 byte offsets for the status-word kind, or between the set and clear bit branches, moves the not-taken and taken targets by one. Negative displacements and a jump from 0xFFFF test sign extension and wrap, which a zero-extending adder would get wrong by 256 or push past 16 bits. Accumulator-kind vectors set bit_val_i against the chosen A bit, which exposes a design that reads the wrong source. A not-taken test-and-clear must raise no write, so a design that clears the bit on every test-and-clear shows up at clr_we_o. A start issued mid-resolution must leave the first result untouched.

// File: rtl/brr_pkg.sv
package brr_pkg;

    typedef enum logic [3:0] {
        OP_JABS = 4'd0,
        OP_JREL = 4'd1,
        OP_JAX  = 4'd2,
        OP_BCS  = 4'd3,
        OP_BCC  = 4'd4,
        OP_BZS  = 4'd5,
        OP_BZC  = 4'd6,
        OP_BTS  = 4'd7,
        OP_BTC  = 4'd8,
        OP_BTCL = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        K_DIR = 3'd0,
        K_SFR = 3'd1,
        K_ACC = 3'd2,
        K_PSW = 3'd3,
        K_IND = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVAL   = 2'd1,
        ST_RESULT = 2'd2
    } st_e;

    // clock counts
    localparam int unsigned CYC_SHORT  = 12;
    localparam int unsigned CYC_MID    = 16;
    localparam int unsigned CYC_TEST   = 20;
    localparam int unsigned CYC_LONG   = 22;
    localparam int unsigned CYC_TCLR   = 24;

    // instruction lengths
    localparam int unsigned LEN_SHORT = 2;
    localparam int unsigned LEN_ABS   = 3;
    localparam int unsigned LEN_BIT   = 3;
    localparam int unsigned LEN_WIDE  = 4;

endpackage

// File: rtl/brr_cond.sv
module brr_cond
    import brr_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  op_e              op,
    input  kind_e            kind,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [DATA_W-1:0] acc,
    input  logic             cy,
    input  logic             z,
    input  logic             bit_val,
    output logic             taken,
    output logic             is_clear
);
    logic tested;

    always_comb begin
        tested   = (kind == K_ACC) ? acc[bit_idx] : bit_val;
        is_clear = (op == OP_BTCL);
        unique case (op)
            OP_JABS, OP_JREL, OP_JAX: taken = 1'b1;
            OP_BCS:                   taken = cy;
            OP_BCC:                   taken = ~cy;
            OP_BZS:                   taken = z;
            OP_BZC:                   taken = ~z;
            OP_BTS, OP_BTCL:          taken = tested;
            OP_BTC:                   taken = ~tested;
            default:                  taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/brr_target.sv
module brr_target
    import brr_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int DISP_W = 8,
    localparam int LEN_W = 3
) (
    input  op_e               op,
    input  kind_e             kind,
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   addr,
    input  logic [DISP_W-1:0] disp,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] x,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    logic [LEN_W-1:0] len;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  rel_pc;
    logic [PC_W-1:0]  disp_ext;
    logic             wide_clear;

    always_comb begin
        wide_clear = (kind == K_DIR) || (kind == K_SFR) || (kind == K_PSW);
        unique case (op)
            OP_JABS:                                 len = LEN_W'(LEN_ABS);
            OP_JREL, OP_JAX, OP_BCS, OP_BCC,
            OP_BZS, OP_BZC:                          len = LEN_W'(LEN_SHORT);
            OP_BTS:  len = (kind == K_SFR) ? LEN_W'(LEN_WIDE) : LEN_W'(LEN_BIT);
            OP_BTC, OP_BTCL:
                     len = wide_clear ? LEN_W'(LEN_WIDE) : LEN_W'(LEN_BIT);
            default:                                 len = '0;
        endcase
    end

    assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    assign seq_pc   = pc + PC_W'(len);
    assign rel_pc   = seq_pc + disp_ext;

    always_comb begin
        unique case (op)
            OP_JABS: next_pc = addr;
            OP_JAX:  next_pc = PC_W'({acc, x});
            OP_JREL, OP_BCS, OP_BCC, OP_BZS, OP_BZC,
            OP_BTS, OP_BTC, OP_BTCL:
                     next_pc = taken ? rel_pc : seq_pc;
            default: next_pc = pc;
        endcase
    end

endmodule

// File: rtl/brr_cycles.sv
module brr_cycles
    import brr_pkg::*;
#(
    parameter int WAIT_W = 2,
    parameter int CYC_W  = 8
) (
    input  op_e               op,
    input  kind_e             kind,
    input  logic [WAIT_W-1:0] rd_wait,
    input  logic [WAIT_W-1:0] wr_wait,
    output logic [CYC_W-1:0]  cycles
);
    logic [CYC_W-1:0] rd_extra;
    logic [CYC_W-1:0] wr_extra;

    assign rd_extra = CYC_W'({rd_wait, 1'b0});
    assign wr_extra = CYC_W'({wr_wait, 1'b0});

    always_comb begin
        unique case (op)
            OP_JABS, OP_JREL, OP_BCS, OP_BCC, OP_BZS, OP_BZC:
                cycles = CYC_W'(CYC_SHORT);
            OP_JAX:
                cycles = CYC_W'(CYC_MID);
            OP_BTS: begin
                case (kind)
                    K_SFR:   cycles = CYC_W'(CYC_LONG);
                    K_IND:   cycles = CYC_W'(CYC_TEST) + rd_extra;
                    default: cycles = CYC_W'(CYC_MID);
                endcase
            end
            OP_BTC: begin
                case (kind)
                    K_DIR:        cycles = CYC_W'(CYC_TEST);
                    K_SFR, K_PSW: cycles = CYC_W'(CYC_LONG);
                    K_IND:        cycles = CYC_W'(CYC_TEST) + rd_extra;
                    default:      cycles = CYC_W'(CYC_MID);
                endcase
            end
            OP_BTCL: begin
                case (kind)
                    K_DIR:        cycles = CYC_W'(CYC_TEST);
                    K_SFR, K_PSW: cycles = CYC_W'(CYC_TCLR);
                    K_IND:        cycles = CYC_W'(CYC_TCLR) + rd_extra + wr_extra;
                    default:      cycles = CYC_W'(CYC_MID);
                endcase
            end
            default: cycles = '0;
        endcase
    end

endmodule

// File: rtl/brr_unit.sv
module brr_unit
    import brr_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int DISP_W = 8,
    parameter int WAIT_W = 2,
    parameter int CYC_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [2:0]        kind_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   addr_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic              cy_i,
    input  logic              z_i,
    input  logic              bit_val_i,
    input  logic [WAIT_W-1:0] rd_wait_i,
    input  logic [WAIT_W-1:0] wr_wait_i,
    output logic              done_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              clr_we_o,
    output logic [2:0]        clr_space_o,
    output logic [DATA_W-1:0] clr_mask_o,
    output logic [CYC_W-1:0]  cycles_o
);
    st_e st_q, st_d;

    op_e               op_q;
    kind_e             kind_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   addr_q;
    logic [DISP_W-1:0] disp_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] x_q;
    logic              cy_q;
    logic              z_q;
    logic              bv_q;
    logic [WAIT_W-1:0] rw_q;
    logic [WAIT_W-1:0] ww_q;

    logic              taken_c;
    logic              clear_c;
    logic [PC_W-1:0]   next_pc_c;
    logic [CYC_W-1:0]  cycles_c;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: accept, resolve, retire
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_EVAL;
            ST_EVAL:   st_d = ST_RESULT;
            ST_RESULT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // operand capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_JABS;
            kind_q <= K_DIR;
            bidx_q <= '0;
            pc_q   <= '0;
            addr_q <= '0;
            disp_q <= '0;
            acc_q  <= '0;
            x_q    <= '0;
            cy_q   <= 1'b0;
            z_q    <= 1'b0;
            bv_q   <= 1'b0;
            rw_q   <= '0;
            ww_q   <= '0;
        end else if (st_q == ST_IDLE && start_i) begin
            op_q   <= op_e'(op_i);
            kind_q <= kind_e'(kind_i);
            bidx_q <= bit_idx_i;
            pc_q   <= pc_i;
            addr_q <= addr_i;
            disp_q <= disp_i;
            acc_q  <= acc_i;
            x_q    <= x_i;
            cy_q   <= cy_i;
            z_q    <= z_i;
            bv_q   <= bit_val_i;
            rw_q   <= rd_wait_i;
            ww_q   <= wr_wait_i;
        end
    end

    brr_cond #(.DATA_W(DATA_W)) u_cond (
        .op       (op_q),
        .kind     (kind_q),
        .bit_idx  (bidx_q),
        .acc      (acc_q),
        .cy       (cy_q),
        .z        (z_q),
        .bit_val  (bv_q),
        .taken    (taken_c),
        .is_clear (clear_c)
    );

    brr_target #(.PC_W(PC_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) u_target (
        .op      (op_q),
        .kind    (kind_q),
        .pc      (pc_q),
        .addr    (addr_q),
        .disp    (disp_q),
        .acc     (acc_q),
        .x       (x_q),
        .taken   (taken_c),
        .next_pc (next_pc_c)
    );

    brr_cycles #(.WAIT_W(WAIT_W), .CYC_W(CYC_W)) u_cycles (
        .op      (op_q),
        .kind    (kind_q),
        .rd_wait (rw_q),
        .wr_wait (ww_q),
        .cycles  (cycles_c)
    );

    // output registers, loaded on resolve
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            next_pc_o   <= '0;
            taken_o     <= 1'b0;
            clr_we_o    <= 1'b0;
            clr_space_o <= '0;
            clr_mask_o  <= '0;
            cycles_o    <= '0;
        end else if (st_q == ST_EVAL) begin
            done_o      <= 1'b1;
            next_pc_o   <= next_pc_c;
            taken_o     <= taken_c;
            clr_we_o    <= taken_c & clear_c;
            clr_space_o <= (taken_c & clear_c) ? kind_q : 3'd0;
            clr_mask_o  <= (taken_c & clear_c) ? (DATA_W'(1) << bidx_q) : '0;
            cycles_o    <= cycles_c;
        end else begin
            done_o      <= 1'b0;
            clr_we_o    <= 1'b0;
            clr_space_o <= '0;
            clr_mask_o  <= '0;
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_i) |=> ##1 done_o);

    assert_clr_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_o |-> (taken_o && done_o));

    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_o |-> ($countones(clr_mask_o) == 1));

    assert_uncond_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_q == OP_JABS || op_q == OP_JAX || op_q == OP_JREL)) |-> taken_o);

endmodule

// File: tb/sim_brr_unit.sv
module sim_brr_unit;
    localparam int PERIOD = 10;
    localparam int NV = 26;

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  kind;
        logic [2:0]  bidx;
        logic [15:0] pc;
        logic [15:0] addr;
        logic [7:0]  disp;
        logic [7:0]  acc;
        logic [7:0]  x;
        logic        cy;
        logic        z;
        logic        bv;
        logic [1:0]  rw;
        logic [1:0]  ww;
        logic [15:0] e_pc;
        logic        e_tk;
        logic        e_we;
        logic [7:0]  e_mask;
        logic [7:0]  e_cyc;
        logic [3:0]  req;
    } vec_t;

    // op kind bidx pc addr disp acc x cy z bv rw ww | pc tk we mask cyc req
    localparam vec_t VECS [NV] = '{
        '{4'd0,3'd0,3'd0,16'h1000,16'h2345,8'h00,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h2345,1'b1,1'b0,8'h00,8'd12, 4'd3},  // R3
        '{4'd1,3'd0,3'd0,16'h1000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h1012,1'b1,1'b0,8'h00,8'd12, 4'd4},  // R4
        '{4'd1,3'd0,3'd0,16'h1000,16'h0000,8'hF0,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h0FF2,1'b1,1'b0,8'h00,8'd12, 4'd4},  // R4 negative
        '{4'd1,3'd0,3'd0,16'hFFFF,16'h0000,8'h05,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h0006,1'b1,1'b0,8'h00,8'd12, 4'd4},  // R4 wrap
        '{4'd2,3'd0,3'd0,16'h1000,16'h0000,8'h00,8'h12,8'h34,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h1234,1'b1,1'b0,8'h00,8'd16, 4'd3},  // R3
        '{4'd3,3'd0,3'd0,16'h2000,16'h0000,8'h7F,8'h00,8'h00,1'b1,1'b0,1'b0,2'd0,2'd0, 16'h2081,1'b1,1'b0,8'h00,8'd12, 4'd5},  // R5
        '{4'd3,3'd0,3'd0,16'h2000,16'h0000,8'h7F,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h2002,1'b0,1'b0,8'h00,8'd12, 4'd7},  // R7
        '{4'd4,3'd0,3'd0,16'h2000,16'h0000,8'h80,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h1F82,1'b1,1'b0,8'h00,8'd12, 4'd5},  // R5
        '{4'd5,3'd0,3'd0,16'h0000,16'h0000,8'hFE,8'h00,8'h00,1'b0,1'b1,1'b0,2'd0,2'd0, 16'h0000,1'b1,1'b0,8'h00,8'd12, 4'd5},  // R5
        '{4'd6,3'd0,3'd0,16'h0000,16'h0000,8'hFE,8'h00,8'h00,1'b0,1'b1,1'b0,2'd0,2'd0, 16'h0002,1'b0,1'b0,8'h00,8'd12, 4'd7},  // R7
        '{4'd7,3'd2,3'd5,16'h3000,16'h0000,8'h10,8'h20,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h3013,1'b1,1'b0,8'h00,8'd16, 4'd6},  // R6 acc bit
        '{4'd7,3'd1,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3014,1'b1,1'b0,8'h00,8'd22, 4'd6},  // R6
        '{4'd7,3'd3,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3013,1'b1,1'b0,8'h00,8'd16, 4'd6},  // R6
        '{4'd7,3'd4,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd3,2'd0, 16'h3013,1'b1,1'b0,8'h00,8'd26, 4'd10}, // R10
        '{4'd8,3'd3,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h3014,1'b1,1'b0,8'h00,8'd22, 4'd6},  // R6
        '{4'd8,3'd0,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3004,1'b0,1'b0,8'h00,8'd20, 4'd7},  // R7
        '{4'd8,3'd2,3'd0,16'h3000,16'h0000,8'h10,8'hFE,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3013,1'b1,1'b0,8'h00,8'd16, 4'd6},  // R6 bv ignored
        '{4'd9,3'd3,3'd6,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3014,1'b1,1'b1,8'h40,8'd24, 4'd8},  // R8
        '{4'd9,3'd3,3'd6,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h3004,1'b0,1'b0,8'h00,8'd24, 4'd8},  // R8 no clear
        '{4'd9,3'd4,3'd2,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd2,2'd1, 16'h3013,1'b1,1'b1,8'h04,8'd30, 4'd10}, // R10
        '{4'd9,3'd1,3'd3,16'h3000,16'h0000,8'hF0,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h2FF4,1'b1,1'b1,8'h08,8'd24, 4'd8},  // R8
        '{4'd9,3'd2,3'd7,16'h3000,16'h0000,8'h10,8'h80,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h3013,1'b1,1'b1,8'h80,8'd16, 4'd8},  // R8 acc
        '{4'd15,3'd0,3'd0,16'h4567,16'h0000,8'h10,8'h00,8'h00,1'b1,1'b1,1'b1,2'd0,2'd0, 16'h4567,1'b0,1'b0,8'h00,8'd0, 4'd11}, // R11
        '{4'd7,3'd0,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b0,2'd0,2'd0, 16'h3003,1'b0,1'b0,8'h00,8'd16, 4'd9},  // R9
        '{4'd8,3'd4,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b0,2'd1,2'd3, 16'h3013,1'b1,1'b0,8'h00,8'd22, 4'd10}, // R10
        '{4'd10,3'd0,3'd0,16'h3000,16'h0000,8'h10,8'h00,8'h00,1'b0,1'b0,1'b1,2'd0,2'd0, 16'h3000,1'b0,1'b0,8'h00,8'd0, 4'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [2:0]  kind = '0;
    logic [2:0]  bidx = '0;
    logic [15:0] pc = '0;
    logic [15:0] addr = '0;
    logic [7:0]  disp = '0;
    logic [7:0]  acc = '0;
    logic [7:0]  x = '0;
    logic        cy = 1'b0;
    logic        z = 1'b0;
    logic        bv = 1'b0;
    logic [1:0]  rw = '0;
    logic [1:0]  ww = '0;

    logic        done;
    logic [15:0] npc;
    logic        tk;
    logic        we;
    logic [2:0]  space;
    logic [7:0]  mask;
    logic [7:0]  cyc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    brr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .kind_i(kind),
        .bit_idx_i(bidx), .pc_i(pc), .addr_i(addr), .disp_i(disp), .acc_i(acc),
        .x_i(x), .cy_i(cy), .z_i(z), .bit_val_i(bv), .rd_wait_i(rw), .wr_wait_i(ww),
        .done_o(done), .next_pc_o(npc), .taken_o(tk), .clr_we_o(we),
        .clr_space_o(space), .clr_mask_o(mask), .cycles_o(cyc)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        op = v.op; kind = v.kind; bidx = v.bidx; pc = v.pc; addr = v.addr;
        disp = v.disp; acc = v.acc; x = v.x; cy = v.cy; z = v.z; bv = v.bv;
        rw = v.rw; ww = v.ww;
    endtask

    task automatic check_result(input vec_t v, input string tag);
        check(tag, "done", 32'(done), 32'd1);
        check(tag, "next_pc", 32'(npc), 32'(v.e_pc));
        check(tag, "taken", 32'(tk), 32'(v.e_tk));
        check(tag, "clr_we", 32'(we), 32'(v.e_we));
        check(tag, "clr_mask", 32'(mask), 32'(v.e_mask));
        if (v.e_we) check(tag, "clr_space", 32'(space), 32'(v.kind));
        check(tag, "cycles", 32'(cyc), 32'(v.e_cyc));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", "done in reset", 32'(done), 32'd0);
        check("R1", "taken in reset", 32'(tk), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", 32'(done), 32'd0);
        check("R1", "clr_we after reset", 32'(we), 32'd0);
        check("R1", "clr_mask after reset", 32'(mask), 32'd0);
        check("R1", "next_pc after reset", 32'(npc), 32'd0);
        check("R1", "cycles after reset", 32'(cyc), 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check($sformatf("R2 vec%0d", i), "done early", 32'(done), 32'd0);
            @(negedge clk);
            check_result(VECS[i], $sformatf("R%0d vec%0d", VECS[i].req, i));
            @(negedge clk);
            check($sformatf("R2 vec%0d", i), "done single cycle", 32'(done), 32'd0);
        end

        // R2: a start while busy is ignored
        apply(VECS[0]);
        start = 1'b1;
        @(negedge clk);
        apply(VECS[4]);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy", "next_pc keeps first", 32'(npc), 32'h2345);
        check("R2 busy", "cycles keeps first", 32'(cyc), 32'd12);
        @(negedge clk);
        check("R2 busy", "no second done", 32'(done), 32'd0);
        @(negedge clk);
        check("R2 busy", "still idle", 32'(done), 32'd0);

        // R1: reset mid-flight clears outputs
        apply(VECS[17]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 midreset", "done", 32'(done), 32'd0);
        check("R1 midreset", "clr_we", 32'(we), 32'd0);
        check("R1 midreset", "next_pc", 32'(npc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 midreset", "done after release", 32'(done), 32'd0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule